// File: doc/BRIEF.md
# PCI Target Write Parity Guard

This block sits beside a PCI target interface and judges the parity of every target write. It computes the expected parity of each address phase and each data phase of a write. It compares that value with the PAR line one clock later. It then decides what the rest of the target must do. If the address parity is bad and the write carries several data phases, the block requests a target abort. If the address parity is bad and the write is a single-phase write, the block lets the transfer finish normally but holds back the downstream write. If a data word has bad parity, the block marks that word as errored and still passes it on.

The block drives the bus error lines PERR# and SERR#. It keeps three sticky status bits: signalled target abort, detected parity error and signalled system error. Software clears them by writing 1. Two enable inputs gate the error lines: one for parity-error response and one for system-error response. Read transactions are never checked by this block, so a read leaves every output and status bit untouched.

Top module: `tpg_guard`

## Requirements
- R1: Parity is even over AD[31:0] and C/BE#[3:0] of a phase: PAR sampled in the clock after that phase must equal the XOR of those 36 bits, and any other value is a parity error.
- R2: When `addr_stb_i` is high in cycle t with `is_wr_i`=1 and the address parity is bad, and `frame_n_i` is 0 in cycle t+1, `abort_req_o` is high for exactly cycle t+2 and `sta_o` reads 1 from cycle t+2.
- R3: When the address parity is bad and `frame_n_i` is 1 in cycle t+1 (single data phase), `abort_req_o` stays low and `suppress_wr_o` is 1 from cycle t+2. It returns to 0 in the cycle after the next address strobe.
- R4: Any detected address or data parity error on a write sets `dpe_o` two cycles after the errored phase.
- R5: An address parity error on a write drives `serr_n_o` low for exactly cycle t+2 and sets `sse_o`, but only when `ser_en_i` is 1 in cycle t+1. Otherwise `serr_n_o` stays high and `sse_o` is unchanged.
- R6: A data phase of a write in cycle d with bad parity gives `word_err_o`=1 in cycle d+2. `perr_n_o` is low for that cycle only when `per_en_i` is 1 in cycle d+1.
- R7: Every write data phase in cycle d gives `word_vld_o`=1 in cycle d+2, whether its parity is good or bad. A word with good parity carries `word_err_o`=0.
- R8: A transaction whose address strobe sees `is_wr_i`=0 changes no output and no status bit, whatever PAR carries.
- R9: `sts_clr_i` is write-1-to-clear with bit 0 = STA, bit 1 = DPE, bit 2 = SSE. A bit being set in the same cycle wins over its clear, and bits not written keep their value.
- R10: After reset, `perr_n_o` and `serr_n_o` are 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_i | input | 32 | Sampled AD lines |
| cbe_n_i | input | 4 | Sampled C/BE# lines |
| par_i | input | 1 | Sampled PAR line (belongs to the previous phase) |
| frame_n_i | input | 1 | Sampled FRAME# |
| addr_stb_i | input | 1 | Address phase of a transaction claimed by this target |
| data_stb_i | input | 1 | Data phase completes this cycle |
| is_wr_i | input | 1 | Transaction is a write, valid with `addr_stb_i` |
| per_en_i | input | 1 | Parity-error response enable |
| ser_en_i | input | 1 | System-error response enable |
| sts_clr_i | input | 3 | Write-1-to-clear strobes for STA, DPE, SSE |
| abort_req_o | output | 1 | Target-abort request pulse |
| suppress_wr_o | output | 1 | Hold back the downstream write |
| word_vld_o | output | 1 | A write data word has been judged |
| word_err_o | output | 1 | That word carried bad parity |
| perr_n_o | output | 1 | PERR# drive, active low |
| serr_n_o | output | 1 | SERR# drive, active low |
| sta_o | output | 1 | Sticky signalled-target-abort bit |
| dpe_o | output | 1 | Sticky detected-parity-error bit |
| sse_o | output | 1 | Sticky signalled-system-error bit |

## Verification
A wrong transaction-kind flag shows in two cycles. Either `word_vld_o` pulses during a read, or it stays silent during a write. A stale stored parity shows as a false `word_err_o` or a false `perr_n_o` exactly two cycles after the phase. A bad single/multi decision shows either as an abort pulse where the suppress level belongs, or the reverse. A sticky bit that leaks or fails to clear stays wrong at the status ports until the next clear strobe. The sweep therefore checks every output in every cycle of each transaction, not only at its end.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;
   localparam int ST_STA = 0;
   localparam int ST_DPE = 1;
   localparam int ST_SSE = 2;
   localparam int ST_N   = 3;
endpackage

// File: rtl/tpg_par_stage.sv
`timescale 1ns/1ps
// Captures the expected parity of one phase and compares it with PAR one clock later.
module tpg_par_stage #(
   parameter int AD_W       = 32,
   parameter int BE_W       = 4,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AD_W-1:0] ad_i,
   input  logic [BE_W-1:0] cbe_n_i,
   input  logic            par_i,
   input  logic            stb_i,
   input  logic            qual_i,
   output logic            chk_o,
   output logic            err_o
);
   logic exp_par;
   logic exp_q;
   logic chk_q;

   generate
      if (ODD_PARITY) begin : g_odd
         assign exp_par = ~(^{ad_i, cbe_n_i});
      end else begin : g_even
         assign exp_par = ^{ad_i, cbe_n_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_q <= 1'b0;
         exp_q <= 1'b0;
      end else begin
         chk_q <= stb_i & qual_i;
         exp_q <= exp_par;
      end
   end

   assign chk_o = chk_q;
   assign err_o = chk_q & (par_i != exp_q);
endmodule

// File: rtl/tpg_sticky.sv
`timescale 1ns/1ps
// Bank of sticky status bits, write-1-to-clear, set dominant.
module tpg_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)          q_o[i] <= 1'b0;
            else if (set_i[i])   q_o[i] <= 1'b1;
            else if (clr_i[i])   q_o[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/tpg_guard.sv
`timescale 1ns/1ps
module tpg_guard
   import tpg_pkg::*;
#(
   parameter int AD_W       = 32,
   parameter int BE_W       = 4,
   parameter bit ODD_PARITY = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AD_W-1:0] ad_i,
   input  logic [BE_W-1:0] cbe_n_i,
   input  logic            par_i,
   input  logic            frame_n_i,
   input  logic            addr_stb_i,
   input  logic            data_stb_i,
   input  logic            is_wr_i,
   input  logic            per_en_i,
   input  logic            ser_en_i,
   input  logic [ST_N-1:0] sts_clr_i,
   output logic            abort_req_o,
   output logic            suppress_wr_o,
   output logic            word_vld_o,
   output logic            word_err_o,
   output logic            perr_n_o,
   output logic            serr_n_o,
   output logic            sta_o,
   output logic            dpe_o,
   output logic            sse_o
);
   generate
      if (AD_W != 8 * BE_W) begin : g_bad_width
         $error("tpg_guard: AD_W must be eight times BE_W");
      end
      if (AD_W < 8) begin : g_bad_min
         $error("tpg_guard: AD_W too small");
      end
   endgenerate

   logic            wr_txn_q;
   logic            a_chk, a_err, d_chk, d_err;
   logic            a_multi, a_single;
   logic [ST_N-1:0] st_set, st_q;
   logic            abort_q, sup_q, vld_q, tag_q, perr_q, serr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          wr_txn_q <= 1'b0;
      else if (addr_stb_i) wr_txn_q <= is_wr_i;
   end

   tpg_par_stage #(.AD_W(AD_W), .BE_W(BE_W), .ODD_PARITY(ODD_PARITY)) u_addr (
      .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i), .par_i(par_i),
      .stb_i(addr_stb_i), .qual_i(is_wr_i), .chk_o(a_chk), .err_o(a_err));

   tpg_par_stage #(.AD_W(AD_W), .BE_W(BE_W), .ODD_PARITY(ODD_PARITY)) u_data (
      .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i), .par_i(par_i),
      .stb_i(data_stb_i), .qual_i(wr_txn_q), .chk_o(d_chk), .err_o(d_err));

   // FRAME# in the cycle after the address is the first data phase's FRAME#.
   assign a_multi  = a_err & ~frame_n_i;
   assign a_single = a_err &  frame_n_i;

   always_comb begin
      st_set         = '0;
      st_set[ST_STA] = a_multi;
      st_set[ST_DPE] = a_err | d_err;
      st_set[ST_SSE] = a_err & ser_en_i;
   end

   tpg_sticky #(.N(ST_N)) u_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(sts_clr_i), .q_o(st_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abort_q <= 1'b0;
         sup_q   <= 1'b0;
         vld_q   <= 1'b0;
         tag_q   <= 1'b0;
         perr_q  <= 1'b0;
         serr_q  <= 1'b0;
      end else begin
         abort_q <= a_multi;
         serr_q  <= a_err & ser_en_i;
         perr_q  <= d_err & per_en_i;
         vld_q   <= d_chk;
         tag_q   <= d_err;
         if (a_single)        sup_q <= 1'b1;
         else if (addr_stb_i) sup_q <= 1'b0;
      end
   end

   assign abort_req_o   = abort_q;
   assign suppress_wr_o = sup_q;
   assign word_vld_o    = vld_q;
   assign word_err_o    = tag_q;
   assign perr_n_o      = ~perr_q;
   assign serr_n_o      = ~serr_q;
   assign sta_o         = st_q[ST_STA];
   assign dpe_o         = st_q[ST_DPE];
   assign sse_o         = st_q[ST_SSE];
endmodule

// File: rtl/tpg_guard_chk.sv
`timescale 1ns/1ps
module tpg_guard_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        per_en_i,
   input logic        ser_en_i,
   input logic [2:0]  sts_clr_i,
   input logic        abort_req_o,
   input logic        suppress_wr_o,
   input logic        word_vld_o,
   input logic        word_err_o,
   input logic        perr_n_o,
   input logic        serr_n_o,
   input logic        sta_o,
   input logic        dpe_o,
   input logic        sse_o
);
   p_abort_sets_sta_r2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req_o |-> sta_o);
   p_abort_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req_o |=> !abort_req_o);
   p_no_abort_on_suppress_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suppress_wr_o) |-> !abort_req_o);
   p_tag_sets_dpe_r4: assert property (@(posedge clk) disable iff (!rst_n)
      word_err_o |-> dpe_o);
   p_serr_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |-> (sse_o && $past(ser_en_i)));
   p_serr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n_o |=> serr_n_o);
   p_perr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !perr_n_o |-> (word_err_o && dpe_o && $past(per_en_i)));
   p_tag_needs_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_err_o |-> word_vld_o);
   p_sta_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sta_o && !sts_clr_i[0]) |=> sta_o);
   p_sse_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sse_o && !sts_clr_i[2]) |=> sse_o);
endmodule

bind tpg_guard tpg_guard_chk chk_i (.*);

// File: tb/tpg_guard_tb.sv
`timescale 1ns/1ps
module tpg_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;
   logic        par = 1'b0, frame_n = 1'b1, addr_stb = 1'b0, data_stb = 1'b0;
   logic        is_wr = 1'b0, per_en = 1'b0, ser_en = 1'b0;
   logic [2:0]  sts_clr = '0;
   logic        abort_req, suppress_wr, word_vld, word_err, perr_n, serr_n, sta, dpe, sse;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic sup_now = 1'b0;

   always #2.5 clk = ~clk;

   tpg_guard dut_i (
      .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par),
      .frame_n_i(frame_n), .addr_stb_i(addr_stb), .data_stb_i(data_stb),
      .is_wr_i(is_wr), .per_en_i(per_en), .ser_en_i(ser_en), .sts_clr_i(sts_clr),
      .abort_req_o(abort_req), .suppress_wr_o(suppress_wr), .word_vld_o(word_vld),
      .word_err_o(word_err), .perr_n_o(perr_n), .serr_n_o(serr_n),
      .sta_o(sta), .dpe_o(dpe), .sse_o(sse));

   task automatic chk(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b", what, $time, act, exp);
      end
   endtask

   function automatic logic pf(input logic [31:0] a, input logic [3:0] c);
      return ^{a, c};
   endfunction

   // One transaction: rd selects a read, nw data phases, abad flips address PAR,
   // dmask bit k-1 flips PAR of data word k, clr1 is written to sts_clr in cycle 1.
   task automatic run_txn(input bit rd, input int nw, input bit abad, input int dmask,
                          input bit pe, input bit se, input logic [2:0] clr1,
                          input logic [2:0] st_in, input int seed);
      logic [31:0] w_ad [0:4];
      logic [3:0]  w_be [0:4];
      bit wr;
      logic e_sta, e_dpe, e_sse, e_sup;
      wr = !rd;
      for (int p = 0; p <= nw; p++) begin
         w_ad[p] = 32'h9e37_79b9 * (seed + p + 1) ^ {seed[7:0], 24'h5a1c3};
         w_be[p] = 4'(seed + 3 * p);
      end
      e_sta = wr & abad & (nw > 1);
      e_dpe = wr & (abad | (dmask != 0));
      e_sse = wr & abad & se;
      e_sup = wr & abad & (nw == 1);
      per_en = pe;
      ser_en = se;
      for (int j = 0; j <= nw + 3; j++) begin
         @(posedge clk); #1;
         addr_stb = (j == 0);
         data_stb = (j >= 1) && (j <= nw);
         is_wr    = (j == 0) ? wr : 1'b0;
         frame_n  = !(j < nw);
         sts_clr  = (j == 0) ? 3'b111 : ((j == 1) ? clr1 : 3'b000);
         if (j <= nw) begin ad = w_ad[j]; cbe_n = w_be[j]; end
         else begin ad = 32'h0; cbe_n = 4'h0; end
         if (j == 0) par = 1'b0;
         else if (j == 1) par = pf(w_ad[0], w_be[0]) ^ abad;
         else if (j <= nw + 1) par = pf(w_ad[j-1], w_be[j-1]) ^ dmask[j-2];
         else par = 1'b0;
         @(negedge clk);
         // R2: abort pulse in cycle 2 only
         chk(abort_req, (j == 2) & e_sta, "R2 abort_req");
         // R5: SERR# low in cycle 2 only
         chk(serr_n, !((j == 2) & e_sse), "R5 serr_n");
         // R7: one judged word per write data phase, two cycles later
         begin
            bit v;
            bit e;
            v = wr && (j >= 3) && (j - 2 <= nw);
            e = v && dmask[(j >= 3 ? j - 3 : 0)];
            chk(word_vld, v, "R7 word_vld");
            chk(word_err, e, "R6 word_err");
            chk(perr_n, !(e & pe), "R6 perr_n");
         end
         // R3: suppress level
         if (j == 0) chk(suppress_wr, sup_now, "R3 suppress_wr before");
         else if (j == 1) chk(suppress_wr, 1'b0, "R3 suppress_wr cleared");
         else chk(suppress_wr, e_sup, "R3 suppress_wr");
         if (j == 1) begin
            // R9: clear of all bits in cycle 0
            chk(sta, 1'b0, "R9 sta cleared");
            chk(dpe, 1'b0, "R9 dpe cleared");
            chk(sse, 1'b0, "R9 sse cleared");
         end
         if (j == 0) begin
            chk(sta, st_in[0], "R9 sta held");
            chk(dpe, st_in[1], "R9 dpe held");
            chk(sse, st_in[2], "R9 sse held");
         end
      end
      sup_now = e_sup;
      // R2 R4 R5 R8: final status (set in cycle 2 wins over clr1)
      chk(sta, e_sta, "R2 sta");
      chk(dpe, e_dpe, "R4 dpe");
      chk(sse, e_sse, "R5 sse");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0] st;
      int seed;
      seed = 1;
      repeat (3) @(posedge clk);
      #1;
      @(negedge clk);
      // R10: reset state
      chk(abort_req, 1'b0, "R10 abort_req");
      chk(suppress_wr, 1'b0, "R10 suppress_wr");
      chk(word_vld, 1'b0, "R10 word_vld");
      chk(word_err, 1'b0, "R10 word_err");
      chk(perr_n, 1'b1, "R10 perr_n");
      chk(serr_n, 1'b1, "R10 serr_n");
      chk(sta, 1'b0, "R10 sta");
      chk(dpe, 1'b0, "R10 dpe");
      chk(sse, 1'b0, "R10 sse");
      @(posedge clk); #1;
      rst_n = 1'b1;
      st = 3'b000;
      // R1 R8: sweep of kind, length, address error, data error masks, enables
      for (int rd = 0; rd < 2; rd++)
         for (int nw = 1; nw <= 3; nw++)
            for (int ab = 0; ab < 2; ab++)
               for (int dm = 0; dm < (1 << nw); dm++)
                  for (int en = 0; en < 4; en++) begin
                     run_txn(rd[0], nw, ab[0], dm, en[0], en[1], 3'b000, st, seed);
                     st = {sse, dpe, sta};
                     seed++;
                  end
      // R9: clear of STA in the cycle its set arrives; set wins
      run_txn(1'b0, 2, 1'b1, 0, 1'b1, 1'b1, 3'b001, st, seed);
      // R9: partial clear of DPE only leaves STA and SSE
      @(posedge clk); #1;
      sts_clr = 3'b010;
      @(posedge clk); #1;
      sts_clr = 3'b000;
      @(negedge clk);
      chk(sta, 1'b1, "R9 sta kept");
      chk(dpe, 1'b0, "R9 dpe cleared alone");
      chk(sse, 1'b1, "R9 sse kept");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule